// File: doc/BRIEF.md
# Paged Memory Window Translator

This block sits between a host memory bus and a card slot and decides, for each host memory access, whether one of a small set of programmable windows claims it. Every window covers a run of 4 KB pages in host space. A claimed access leaves the block with a card address in a 26-bit card space and with three mode bits: common or attribute memory, 8-bit or 16-bit data path, and which of two timing sets the card bus should use.

Software programs the windows one byte at a time through an index/data pair. Each window has an inclusive start page, an inclusive stop page and a page offset. The offset is added to the host page, and the sum wraps inside the card space. A shared enable byte turns each window on or off. The same byte selects full decoding of the host page, or a narrow decode that uses only the low 1 MB of host space.

A strobed host address is resolved in one clock cycle. The result is registered, so the outputs are valid in the cycle after the strobe.

Top module: `memwin_xlate`

## Requirements
- R1: After reset all window registers and the enable byte read as zero. No access hits, and every output is zero.
- R2: A host strobe in the cycle before a clock edge produces a registered result after that edge. The access hits when an enabled window has start page <= host page <= stop page, with both bounds inclusive. The host page is host address bits 23:12.
- R3: On a hit, the card address is (host address + offset_page * 4096) modulo 2^26. Its low 12 bits equal the host address bits 11:0.
- R4: When several enabled windows contain the page, the lowest-numbered window is reported on the window-number output and supplies the offset and the mode bits.
- R5: The byte at index 0x06 holds one enable per window in bits 3:0, with bit k enabling window k. Bits 7, 6 and 4 of that byte are ignored. A disabled window never hits, whatever its range.
- R6: Three mode bits are reported only on a hit. Bit 7 of the start-high byte gives the 16-bit data path. Bit 6 of the stop-high byte gives timing set 1. Bit 6 of the offset-high byte selects attribute space.
- R7: Window k's bytes sit at index 0x10 + 8*k + f. Field f is 0 for start low, 1 for start high, 2 for stop low, 3 for stop high, 4 for offset low and 5 for offset high. The start-high and stop-high bytes carry page bits 11:8 in their bits 3:0. The offset-high byte carries offset bits 13:8 in its bits 5:0. All other bits of these bytes are ignored, and writing one byte leaves the window's other fields unchanged.
- R8: Bit 5 of the enable byte selects full decoding. When the bit is clear, host address bits 23:20 and start/stop page bits 11:8 are treated as zero for both matching and translation.
- R9: A cycle without a strobe, or an access that no window claims, gives no hit in the following cycle. In that case the card address, the mode bits and the window number are all zero.
- R10: Writes to indices outside the enable byte and the six bytes of each window change no translation. This covers 0x00-0x05, 0x07, offsets 6 and 7 of each window, and indices above the last window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| host_stb | input | 1 | Host memory access strobe |
| host_addr | input | HOST_AW (24) | Host byte address |
| xl_hit | output | 1 | A window claimed the access |
| xl_card_addr | output | CARD_AW (26) | Translated card byte address |
| xl_attr | output | 1 | Access goes to attribute space |
| xl_wide16 | output | 1 | 16-bit data path selected |
| xl_tset1 | output | 1 | Timing set 1 selected |
| xl_win | output | WIN_IDX_W (2) | Number of the claiming window |

## Verification
Register state that is wrong shows up only when an access falls in the affected range, one cycle after that access is strobed. Depending on the fault, the outputs show a missing or extra hit, the wrong winning window, a card page off by the error, or a flipped mode bit. The bench therefore sweeps every host page under several window layouts. These layouts include overlaps, an offset that wraps, disabled windows and narrow decoding, so a stale byte or a misrouted field is caught within one sweep of its page. The no-effect requirements are checked by writing stray indices and sweeping again.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

   localparam int PAGE_SHIFT = 12;

   // Index of the shared enable byte.
   localparam logic [7:0] IDX_WIN_ENABLE = 8'h06;

   // Window k occupies index slot (WIN_BASE_SLOT + k), i.e. index 0x10 + 8*k.
   localparam int WIN_BASE_SLOT = 2;

   // Bit positions inside the configuration bytes.
   localparam int BIT_ENA_WIDE_DECODE = 5;
   localparam int BIT_START_W16       = 7;
   localparam int BIT_STOP_TSET1      = 6;
   localparam int BIT_OFF_ATTR        = 6;

   typedef enum logic [2:0] {
      FLD_START_LO = 3'd0,
      FLD_START_HI = 3'd1,
      FLD_STOP_LO  = 3'd2,
      FLD_STOP_HI  = 3'd3,
      FLD_OFF_LO   = 3'd4,
      FLD_OFF_HI   = 3'd5
   } win_fld_e;

   typedef struct packed {
      logic wide16;
      logic tset1;
      logic attr;
   } win_mode_t;

endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
   import memwin_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int HPAGE_W = 12,
   parameter int CPAGE_W = 14
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [7:0]                        cfg_idx,
   input  logic [7:0]                        cfg_wdata,
   output logic [NUM_WIN-1:0]                win_en,
   output logic                              wide_dec,
   output logic [NUM_WIN-1:0][HPAGE_W-1:0]   start_pg,
   output logic [NUM_WIN-1:0][HPAGE_W-1:0]   stop_pg,
   output logic [NUM_WIN-1:0][CPAGE_W-1:0]   off_pg,
   output win_mode_t [NUM_WIN-1:0]           mode
);

   localparam int HHI_W = HPAGE_W - 8;
   localparam int CHI_W = CPAGE_W - 8;

   // Shared enable byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_en   <= '0;
         wide_dec <= 1'b0;
      end else if (cfg_we && (cfg_idx == IDX_WIN_ENABLE)) begin
         win_en   <= cfg_wdata[NUM_WIN-1:0];
         wide_dec <= cfg_wdata[BIT_ENA_WIDE_DECODE];
      end
   end

   // Per-window byte registers
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [4:0] SLOT = 5'(WIN_BASE_SLOT + i);

      logic             sel;
      logic [7:0]       st_lo, sp_lo, of_lo;
      logic [HHI_W-1:0] st_hi, sp_hi;
      logic [CHI_W-1:0] of_hi;
      logic             w16_q, t1_q, attr_q;

      assign sel = cfg_we && (cfg_idx[7:3] == SLOT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_lo  <= '0;
            st_hi  <= '0;
            sp_lo  <= '0;
            sp_hi  <= '0;
            of_lo  <= '0;
            of_hi  <= '0;
            w16_q  <= 1'b0;
            t1_q   <= 1'b0;
            attr_q <= 1'b0;
         end else if (sel) begin
            case (win_fld_e'(cfg_idx[2:0]))
               FLD_START_LO: st_lo <= cfg_wdata;
               FLD_START_HI: begin
                  st_hi <= cfg_wdata[HHI_W-1:0];
                  w16_q <= cfg_wdata[BIT_START_W16];
               end
               FLD_STOP_LO:  sp_lo <= cfg_wdata;
               FLD_STOP_HI: begin
                  sp_hi <= cfg_wdata[HHI_W-1:0];
                  t1_q  <= cfg_wdata[BIT_STOP_TSET1];
               end
               FLD_OFF_LO:   of_lo <= cfg_wdata;
               FLD_OFF_HI: begin
                  of_hi  <= cfg_wdata[CHI_W-1:0];
                  attr_q <= cfg_wdata[BIT_OFF_ATTR];
               end
               default: ;
            endcase
         end
      end

      assign start_pg[i] = {st_hi, st_lo};
      assign stop_pg[i]  = {sp_hi, sp_lo};
      assign off_pg[i]   = {of_hi, of_lo};
      assign mode[i]     = '{wide16: w16_q, tset1: t1_q, attr: attr_q};
   end

endmodule

// File: rtl/memwin_match.sv
module memwin_match #(
   parameter int HPAGE_W  = 12,
   parameter int NARROW_W = 8
) (
   input  logic               en,
   input  logic               wide_dec,
   input  logic [HPAGE_W-1:0] page,
   input  logic [HPAGE_W-1:0] start_pg,
   input  logic [HPAGE_W-1:0] stop_pg,
   output logic               hit
);

   localparam logic [HPAGE_W-1:0] NARROW_MASK = HPAGE_W'((1 << NARROW_W) - 1);

   logic [HPAGE_W-1:0] mask, p, lo, hi;

   always_comb begin
      mask = wide_dec ? '1 : NARROW_MASK;
      p    = page & mask;
      lo   = start_pg & mask;
      hi   = stop_pg & mask;
      hit  = en && (p >= lo) && (p <= hi);
   end

endmodule

// File: rtl/memwin_pick.sv
module memwin_pick
   import memwin_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int CPAGE_W = 14,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_WIN-1:0]              match,
   input  logic [NUM_WIN-1:0][CPAGE_W-1:0] off_pg,
   input  win_mode_t [NUM_WIN-1:0]         mode,
   output logic [NUM_WIN-1:0]              grant,
   output logic                            any,
   output logic [IDX_W-1:0]                sel_idx,
   output logic [CPAGE_W-1:0]              sel_off,
   output win_mode_t                       sel_mode
);

   // Scan from the top down so that the lowest matching window is applied last.
   always_comb begin
      grant    = '0;
      sel_idx  = '0;
      sel_off  = '0;
      sel_mode = '0;
      for (int k = NUM_WIN - 1; k >= 0; k--) begin
         if (match[k]) begin
            grant    = '0;
            grant[k] = 1'b1;
            sel_idx  = IDX_W'(k);
            sel_off  = off_pg[k];
            sel_mode = mode[k];
         end
      end
      any = |match;
   end

endmodule

// File: rtl/memwin_xlate.sv
module memwin_xlate
   import memwin_pkg::*;
#(
   parameter int NUM_WIN   = 4,
   parameter int HOST_AW   = 24,
   parameter int CARD_AW   = 26,
   parameter int NARROW_AW = 20,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [7:0]           cfg_idx,
   input  logic [7:0]           cfg_wdata,
   input  logic                 host_stb,
   input  logic [HOST_AW-1:0]   host_addr,
   output logic                 xl_hit,
   output logic [CARD_AW-1:0]   xl_card_addr,
   output logic                 xl_attr,
   output logic                 xl_wide16,
   output logic                 xl_tset1,
   output logic [WIN_IDX_W-1:0] xl_win
);

   localparam int HPAGE_W   = HOST_AW - PAGE_SHIFT;
   localparam int CPAGE_W   = CARD_AW - PAGE_SHIFT;
   localparam int NARROW_PW = NARROW_AW - PAGE_SHIFT;
   localparam logic [HPAGE_W-1:0] NARROW_MASK = HPAGE_W'((1 << NARROW_PW) - 1);

   // Elaboration-time parameter checks
   if (NUM_WIN < 1 || NUM_WIN > 4) begin : g_bad_num_win
      $error("memwin_xlate: NUM_WIN must be 1..4");
   end
   if (HPAGE_W < 9 || HPAGE_W > 14) begin : g_bad_host_aw
      $error("memwin_xlate: HOST_AW must give 9..14 page bits");
   end
   if (CPAGE_W < 9 || CPAGE_W > 14) begin : g_bad_card_aw
      $error("memwin_xlate: CARD_AW must give 9..14 page bits");
   end
   if (CARD_AW < HOST_AW) begin : g_bad_card_vs_host
      $error("memwin_xlate: CARD_AW must not be narrower than HOST_AW");
   end
   if (NARROW_PW < 1 || NARROW_AW > HOST_AW) begin : g_bad_narrow
      $error("memwin_xlate: NARROW_AW out of range");
   end

   logic [NUM_WIN-1:0]              win_en;
   logic                            wide_dec;
   logic [NUM_WIN-1:0][HPAGE_W-1:0] start_pg, stop_pg;
   logic [NUM_WIN-1:0][CPAGE_W-1:0] off_pg;
   win_mode_t [NUM_WIN-1:0]         mode;

   memwin_regs #(
      .NUM_WIN (NUM_WIN),
      .HPAGE_W (HPAGE_W),
      .CPAGE_W (CPAGE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .win_en    (win_en),
      .wide_dec  (wide_dec),
      .start_pg  (start_pg),
      .stop_pg   (stop_pg),
      .off_pg    (off_pg),
      .mode      (mode)
   );

   // Effective host page after the decode-width choice
   logic [HPAGE_W-1:0] eff_pg;
   assign eff_pg = wide_dec ? host_addr[HOST_AW-1:PAGE_SHIFT]
                            : (host_addr[HOST_AW-1:PAGE_SHIFT] & NARROW_MASK);

   logic [NUM_WIN-1:0] match;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
      memwin_match #(
         .HPAGE_W  (HPAGE_W),
         .NARROW_W (NARROW_PW)
      ) u_match (
         .en       (win_en[i]),
         .wide_dec (wide_dec),
         .page     (eff_pg),
         .start_pg (start_pg[i]),
         .stop_pg  (stop_pg[i]),
         .hit      (match[i])
      );
   end

   logic [NUM_WIN-1:0]   grant;
   logic                 any;
   logic [WIN_IDX_W-1:0] sel_idx;
   logic [CPAGE_W-1:0]   sel_off;
   win_mode_t            sel_mode;

   memwin_pick #(
      .NUM_WIN (NUM_WIN),
      .CPAGE_W (CPAGE_W),
      .IDX_W   (WIN_IDX_W)
   ) u_pick (
      .match    (match),
      .off_pg   (off_pg),
      .mode     (mode),
      .grant    (grant),
      .any      (any),
      .sel_idx  (sel_idx),
      .sel_off  (sel_off),
      .sel_mode (sel_mode)
   );

   // Card page: host page plus offset, wrapping in the card space
   logic [CPAGE_W-1:0] card_pg;
   assign card_pg = CPAGE_W'(eff_pg) + sel_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_hit       <= 1'b0;
         xl_card_addr <= '0;
         xl_attr      <= 1'b0;
         xl_wide16    <= 1'b0;
         xl_tset1     <= 1'b0;
         xl_win       <= '0;
      end else if (host_stb && any) begin
         xl_hit       <= 1'b1;
         xl_card_addr <= {card_pg, host_addr[PAGE_SHIFT-1:0]};
         xl_attr      <= sel_mode.attr;
         xl_wide16    <= sel_mode.wide16;
         xl_tset1     <= sel_mode.tset1;
         xl_win       <= sel_idx;
      end else begin
         xl_hit       <= 1'b0;
         xl_card_addr <= '0;
         xl_attr      <= 1'b0;
         xl_wide16    <= 1'b0;
         xl_tset1     <= 1'b0;
         xl_win       <= '0;
      end
   end

endmodule

// File: rtl/memwin_xlate_chk.sv
module memwin_xlate_chk #(
   parameter int NUM_WIN   = 4,
   parameter int HOST_AW   = 24,
   parameter int CARD_AW   = 26,
   parameter int WIN_IDX_W = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_stb,
   input logic [HOST_AW-1:0]   host_addr,
   input logic [NUM_WIN-1:0]   win_en,
   input logic [NUM_WIN-1:0]   grant,
   input logic                 xl_hit,
   input logic [CARD_AW-1:0]   xl_card_addr,
   input logic                 xl_attr,
   input logic                 xl_wide16,
   input logic                 xl_tset1,
   input logic [WIN_IDX_W-1:0] xl_win
);

   // Enable vector as seen by the access resolved at the previous edge
   logic [NUM_WIN-1:0] en_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d <= '0;
      else        en_d <= win_en;
   end

   // R1: first cycle out of reset shows no hit
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !xl_hit);

   // R9: no strobe, no hit one cycle later
   a_r9_no_strobe_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !host_stb |=> !xl_hit);

   // R9: a miss leaves every other output at zero
   a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_hit |-> (xl_card_addr == '0 && !xl_attr && !xl_wide16 && !xl_tset1 && xl_win == '0));

   // R3: low 12 bits pass through on a hit
   a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      host_stb |=> (!xl_hit || xl_card_addr[11:0] == $past(host_addr[11:0])));

   // R5: the reported window was enabled when the access was resolved
   a_r5_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      host_stb |=> (!xl_hit || en_d[xl_win]));

   // R4: at most one window is granted
   a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

endmodule

bind memwin_xlate memwin_xlate_chk #(
   .NUM_WIN   (NUM_WIN),
   .HOST_AW   (HOST_AW),
   .CARD_AW   (CARD_AW),
   .WIN_IDX_W (WIN_IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_stb     (host_stb),
   .host_addr    (host_addr),
   .win_en       (win_en),
   .grant        (grant),
   .xl_hit       (xl_hit),
   .xl_card_addr (xl_card_addr),
   .xl_attr      (xl_attr),
   .xl_wide16    (xl_wide16),
   .xl_tset1     (xl_tset1),
   .xl_win       (xl_win)
);

// File: tb/test_memwin_xlate.sv
module test_memwin_xlate;

   localparam int NW  = 4;
   localparam int HAW = 24;
   localparam int CAW = 26;
   localparam int NAW = 20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [7:0]     cfg_idx = '0;
   logic [7:0]     cfg_wdata = '0;
   logic           host_stb = 1'b0;
   logic [HAW-1:0] host_addr = '0;
   logic           xl_hit;
   logic [CAW-1:0] xl_card_addr;
   logic           xl_attr, xl_wide16, xl_tset1;
   logic [1:0]     xl_win;

   always #5 clk = ~clk;

   memwin_xlate #(
      .NUM_WIN   (NW),
      .HOST_AW   (HAW),
      .CARD_AW   (CAW),
      .NARROW_AW (NAW)
   ) i_memwin_xlate (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_idx      (cfg_idx),
      .cfg_wdata    (cfg_wdata),
      .host_stb     (host_stb),
      .host_addr    (host_addr),
      .xl_hit       (xl_hit),
      .xl_card_addr (xl_card_addr),
      .xl_attr      (xl_attr),
      .xl_wide16    (xl_wide16),
      .xl_tset1     (xl_tset1),
      .xl_win       (xl_win)
   );

   int errors = 0;
   int checks = 0;

   // Shadow of the programmed configuration, kept from the bench's own writes
   int s_start[NW];
   int s_stop[NW];
   int s_off[NW];
   bit s_w16[NW];
   bit s_t1[NW];
   bit s_attr[NW];
   bit [3:0] s_en = '0;
   bit s_wide = 1'b0;

   task automatic wr(input logic [7:0] idx, input logic [7:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_idx   = idx;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // R7 layout; unused bits are written as ones to show they are ignored
   task automatic program_win(input int i, input logic [11:0] st, input logic [11:0] sp,
                              input logic [13:0] of, input bit w16, input bit t1, input bit at);
      logic [7:0] base;
      base = 8'(8'h10 + 8 * i);
      wr(base + 8'd0, st[7:0]);
      wr(base + 8'd1, {w16, 3'b111, st[11:8]});
      wr(base + 8'd2, sp[7:0]);
      wr(base + 8'd3, {1'b1, t1, 2'b11, sp[11:8]});
      wr(base + 8'd4, of[7:0]);
      wr(base + 8'd5, {1'b1, at, of[13:8]});
      s_start[i] = int'(st);
      s_stop[i]  = int'(sp);
      s_off[i]   = int'(of);
      s_w16[i]   = w16;
      s_t1[i]    = t1;
      s_attr[i]  = at;
   endtask

   // R5/R8: enable byte, with the ignored bits 7, 6 and 4 set
   task automatic set_en(input bit [3:0] en, input bit wide);
      wr(8'h06, {2'b11, wide, 1'b1, en});
      s_en   = en;
      s_wide = wide;
   endtask

   task automatic model(input logic [HAW-1:0] a, output bit h, output int w,
                        output logic [CAW-1:0] ca, output bit e16, output bit et1, output bit eat);
      int pg, lo, hi, eff;
      h = 0; w = 0; ca = '0; e16 = 0; et1 = 0; eat = 0;
      pg = s_wide ? int'(a[23:12]) : int'(a[19:12]);
      for (int k = 0; k < NW; k++) begin
         lo = s_wide ? s_start[k] : (s_start[k] & 'hFF);
         hi = s_wide ? s_stop[k]  : (s_stop[k]  & 'hFF);
         if (!h && s_en[k] && pg >= lo && pg <= hi) begin
            h = 1;
            w = k;
         end
      end
      if (h) begin
         eff = s_wide ? int'(a) : int'(a[19:0]);
         ca  = CAW'((eff + (s_off[w] << 12)) % (1 << CAW));
         e16 = s_w16[w];
         et1 = s_t1[w];
         eat = s_attr[w];
      end
   endtask

   task automatic compare(input string tag, input logic [HAW-1:0] a, input bit h, input int w,
                          input logic [CAW-1:0] ca, input bit e16, input bit et1, input bit eat);
      checks++;
      if (xl_hit !== h || int'(xl_win) != w || xl_card_addr !== ca ||
          xl_wide16 !== e16 || xl_tset1 !== et1 || xl_attr !== eat) begin
         errors++;
         $display("FAIL %s addr=%h got hit=%b win=%0d card=%h w16=%b t1=%b attr=%b exp hit=%b win=%0d card=%h w16=%b t1=%b attr=%b",
                  tag, a, xl_hit, xl_win, xl_card_addr, xl_wide16, xl_tset1, xl_attr,
                  h, w, ca, e16, et1, eat);
      end
   endtask

   // Strobe at a falling edge, result registered at the next rising edge,
   // sampled at the following falling edge.
   task automatic probe(input string tag, input logic [HAW-1:0] a);
      bit h, e16, et1, eat;
      int w;
      logic [CAW-1:0] ca;
      @(negedge clk);
      host_stb  = 1'b1;
      host_addr = a;
      @(negedge clk);
      host_stb  = 1'b0;
      model(a, h, w, ca, e16, et1, eat);
      compare(tag, a, h, w, ca, e16, et1, eat);
   endtask

   task automatic sweep(input string tag, input int seed);
      for (int pg = 0; pg < 4096; pg++) begin
         logic [11:0] lowb;
         lowb = 12'((pg * 37 + seed) & 'hFFF);
         probe(tag, {12'(pg), lowb});
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired before the run completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < NW; k++) begin
         s_start[k] = 0; s_stop[k] = 0; s_off[k] = 0;
         s_w16[k] = 0; s_t1[k] = 0; s_attr[k] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: outputs quiet out of reset, and page 0 (inside the zero-reset range) misses
      compare("R1 reset outputs", '0, 0, 0, '0, 0, 0, 0);
      probe("R1 reset no hit page0", 24'h000123);
      probe("R1 reset no hit", 24'hABC456);

      // Overlapping windows, one with an offset that wraps the card space
      program_win(0, 12'h100, 12'h1FF, 14'h0000, 1, 0, 0);
      program_win(1, 12'h180, 12'h2FF, 14'h3F00, 0, 1, 1);
      program_win(2, 12'h000, 12'h000, 14'h0005, 1, 1, 1);
      program_win(3, 12'h800, 12'hFFE, 14'h2ABC, 0, 0, 0);
      set_en(4'b1111, 1);
      // R2 R3 R4 R6 R7: full sweep of every host page
      sweep("R2/R3/R4/R6/R7 sweep A", 5);

      // R9: address inside a window without a strobe
      @(negedge clk);
      host_addr = 24'h150ABC;
      @(negedge clk);
      @(negedge clk);
      compare("R9 no strobe", host_addr, 0, 0, '0, 0, 0, 0);

      // R7: single-byte rewrite of window 0 stop-low leaves its other fields
      wr(8'h12, 8'h3F);
      s_stop[0] = 'h13F;
      probe("R7 stop low rewrite inside", 24'h13F001);
      probe("R7 stop low rewrite outside", 24'h140001);
      probe("R7 start kept", 24'h100FFF);
      probe("R2 inclusive start", 24'h180000);
      probe("R2 inclusive stop", 24'h2FFFFF);
      probe("R3 wrap", 24'h2FF123);

      // R10: stray writes, then re-sweep with the unchanged shadow
      for (int j = 0; j < 6; j++) wr(8'(j), 8'hFF);
      wr(8'h07, 8'hFF);
      for (int k = 0; k < NW; k++) begin
         wr(8'(8'h16 + 8 * k), 8'hA5);
         wr(8'(8'h17 + 8 * k), 8'h5A);
      end
      for (int j = 8'h30; j < 8'h40; j++) wr(8'(j), 8'hFF);
      wr(8'h80, 8'hFF);
      wr(8'hFE, 8'hFF);
      sweep("R10 stray writes", 11);

      // R5: disabled windows never hit, even with a range covering free pages
      program_win(2, 12'h300, 12'h7FF, 14'h0001, 1, 0, 1);
      set_en(4'b1010, 1);
      sweep("R5 disabled windows", 23);

      // R8: narrow decode with upper page bits set in start/stop
      program_win(0, 12'hAC0, 12'h5CF, 14'h0123, 1, 1, 0);
      set_en(4'b0011, 0);
      sweep("R8 narrow decode", 97);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule